// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal master and an external asynchronous SRAM bus that has separate address and data lines. It takes one read or write request at a time through a valid/ready handshake and plays it out as a timed sequence of chip select, output enable, write enable and byte-mask strobes. It drives a 25-bit address, a 16-bit bidirectional data bus, eight active-low chip selects and two active-low byte masks. The master supplies a 28-bit internal address: its top three bits pick the chip select and the other 25 bits go out on the address bus.

Strobe timing is set by two cycle counts in units of the bus clock, both sampled when a request is accepted. The first is a setup/hold count m, from 0 to 15. The second is a pulse-width count n, from 1 to 16, which is given as n-1 on a 4-bit input. A read puts m cycles between chip select and output enable. A write puts n cycles between chip select and write enable, and drives its data from the second cycle of the access. Both hold address and chip select for m cycles after the strobe rises. The controller then raises a one-cycle done pulse in a cycle where all strobes are high, and it can take the next request in that same cycle. Read data is captured at the clock edge where output enable rises.

Top module: `sram_bus_ctrl`

## Requirements
Cycle k below counts clock cycles from the first cycle after the accepting clock edge (k = 0). Here m = cfg_setup and n = cfg_width + 1. An access lasts T cycles, with T = 2m+n for a read and T = 2n+m for a write.

- R1: req_ready is high when no access is in progress, which includes the done cycle k = T. It is low for k = 0 to T-1. A request is accepted on a rising clock edge where req_valid and req_ready are both high.
- R2: For k = 0 to T-1, exactly one chip select is low: mem_cs_n[i] is low where i = req_addr[27:25]. mem_addr equals req_addr[24:0] over those same cycles and stays stable. All chip selects are high at k = T.
- R3: For a read, mem_oe_n is low exactly for k = m to m+n-1, and mem_we_n stays high.
- R4: A read ends with chip select held for m cycles after output enable rises. done is high only in cycle k = 2m+n.
- R5: rd_data takes the value present on mem_dq at the clock edge that ends cycle m+n-1, which is the edge where output enable rises. It shows that value from cycle m+n onward and keeps it until the next read captures.
- R6: For a write, mem_we_n is low exactly for k = n to 2n-1, and mem_oe_n stays high.
- R7: The controller drives mem_dq with req_wdata only in a write, for k = 1 to 2n+m-1. At all other times, including every read cycle and idle, it leaves mem_dq undriven.
- R8: A write holds address, data and chip select for m cycles after write enable rises. done is high only in cycle k = 2n+m.
- R9: mem_bm_n equals ~req_be while the access's strobe (output enable or write enable) is low, and 2'b11 at all other times. Bit 0 masks the low byte mem_dq[7:0] and bit 1 masks the high byte.
- R10: mem_oe_n and mem_we_n are never low together. Between two accesses there is at least one cycle with all chip selects, strobes and masks high.
- R11: The request inputs and the timing counts are sampled only at acceptance. Changing them during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Internal address; [27:25] chip select, [24:0] bus address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| cfg_setup | input | 4 | Setup/hold count m (0 to 15) |
| cfg_width | input | 4 | Strobe width minus one (n-1) |
| done | output | 1 | One-cycle pulse at the end of an access |
| rd_data | output | 16 | Captured read data |
| mem_addr | output | 25 | External address bus |
| mem_cs_n | output | 8 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_bm_n | output | 2 | Active-low byte masks |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
Reads and writes run with the smallest timing (m = 0, n = 1), middle values and the largest (m = 15, n = 16). This separates the read rule (setup m) from the write rule (setup n), and it exposes off-by-one errors at the ends of the counters. While output enable is low, the bench model changes the read data every cycle, so only a capture at the rising edge of output enable gives the expected word. Writes use each single byte lane and both lanes together, which checks the mask polarity and the lane order. Back-to-back requests are issued in the done cycle to show the idle gap. Inputs are scrambled right after acceptance to show that they are sampled only once.

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl #(
  parameter int AW  = 25,
  parameter int DW  = 16,
  parameter int CSW = 3,
  parameter int MW  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW+CSW-1:0]   req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic [DW/8-1:0]     req_be,
  input  logic [MW-1:0]       cfg_setup,
  input  logic [MW-1:0]       cfg_width,
  output logic                done,
  output logic [DW-1:0]       rd_data,
  output logic [AW-1:0]       mem_addr,
  output logic [(1<<CSW)-1:0] mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DW/8-1:0]     mem_bm_n,
  inout  wire  [DW-1:0]       mem_dq
);
  localparam int NCS = 1 << CSW;
  localparam int IAW = AW + CSW;
  localparam int NW  = MW + 1;
  localparam int KW  = MW + 3;
  localparam int BW  = DW / 8;

  logic          act;
  logic [KW-1:0] k, last_q, cap_q;
  logic          wr_q, dq_en;
  logic [DW-1:0] wd_q;
  logic [BW-1:0] be_q;
  logic [CSW-1:0] cs_q;
  logic [MW-1:0] m_q;
  logic [NW-1:0] n_q;

  wire accept = req_valid & req_ready;
  assign req_ready = ~act;

  wire            s_wr = accept ? req_write : wr_q;
  wire [MW-1:0]   s_m  = accept ? cfg_setup : m_q;
  wire [NW-1:0]   s_n  = accept ? ({1'b0, cfg_width} + NW'(1)) : n_q;
  wire [BW-1:0]   s_be = accept ? req_be : be_q;
  wire [CSW-1:0]  s_cs = accept ? req_addr[IAW-1 -: CSW] : cs_q;
  wire [KW-1:0]   km   = KW'(s_m);
  wire [KW-1:0]   kn   = KW'(s_n);

  wire           at_end = act & (k == last_q);
  wire           nact   = accept | (act & ~at_end);
  wire [KW-1:0]  nk     = accept ? '0 : k + KW'(1);

  wire oe_d = nact & ~s_wr & (nk >= km) & (nk < km + kn);
  wire we_d = nact &  s_wr & (nk >= kn) & (nk < (kn << 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; k <= '0; last_q <= '0; cap_q <= '0;
      wr_q <= 1'b0; m_q <= '0; n_q <= NW'(1); be_q <= '0; cs_q <= '0;
      wd_q <= '0; mem_addr <= '0; rd_data <= '0; done <= 1'b0;
      mem_cs_n <= '1; mem_oe_n <= 1'b1; mem_we_n <= 1'b1;
      mem_bm_n <= '1; dq_en <= 1'b0;
    end else begin
      act  <= nact;
      k    <= nk;
      done <= at_end;
      if (accept) begin
        wr_q     <= req_write;
        m_q      <= s_m;
        n_q      <= s_n;
        be_q     <= req_be;
        cs_q     <= s_cs;
        wd_q     <= req_wdata;
        mem_addr <= req_addr[AW-1:0];
        last_q   <= s_wr ? ((kn << 1) + km - KW'(1)) : ((km << 1) + kn - KW'(1));
        cap_q    <= km + kn - KW'(1);
      end
      if (act && !wr_q && k == cap_q) rd_data <= mem_dq;
      mem_cs_n <= nact ? ~(NCS'(1) << s_cs) : '1;
      mem_oe_n <= ~oe_d;
      mem_we_n <= ~we_d;
      mem_bm_n <= (oe_d | we_d) ? ~s_be : '1;
      dq_en    <= nact & s_wr & (nk != '0);
    end
  end

  assign mem_dq = dq_en ? wd_q : 'z;

  a_r2_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != '1 && $past(mem_cs_n) != '1) |-> $stable(mem_addr));
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  a_r10_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> mem_cs_n != '1);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_cs_n == '1 && mem_oe_n && mem_we_n && mem_bm_n == '1 && req_ready));
  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    dq_en |-> (mem_oe_n && mem_cs_n != '1));
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != '1) |-> !req_ready);
  a_r9_mask_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe_n && mem_we_n) |-> mem_bm_n == '1);
endmodule

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [27:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic [3:0]  cfg_setup = '0, cfg_width = '0;
  logic        req_ready, done, mem_oe_n, mem_we_n;
  logic [15:0] rd_data;
  logic [24:0] mem_addr;
  logic [7:0]  mem_cs_n;
  logic [1:0]  mem_bm_n;
  wire  [15:0] mem_dq;

  logic        tb_en = 1'b1;
  logic [15:0] rdv = '0;
  assign mem_dq = tb_en ? (!mem_oe_n ? rdv : 16'h0000) : 'z;

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  sram_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .cfg_setup(cfg_setup), .cfg_width(cfg_width),
    .done(done), .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bm_n(mem_bm_n),
    .mem_dq(mem_dq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic access(bit wr, logic [27:0] a, logic [15:0] d, logic [1:0] be,
                        int m, int w, logic [15:0] rbase);
    int t;
    bit oe_exp, we_exp;
    t = wr ? 2*w + m : 2*m + w;
    chk("R1 ready before request", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    cfg_setup = 4'(m); cfg_width = 4'(w - 1);
    @(posedge clk);
    for (int k = 0; k <= t; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
        req_be = ~be; cfg_setup = ~4'(m); cfg_width = ~4'(w - 1);
      end
      tb_en = !(wr && k >= 1 && k < t);
      rdv = 16'(rbase + 16'(k));
      #1;
      oe_exp = !wr && k >= m && k < m + w;
      we_exp = wr && k >= w && k < 2*w;
      chk("R2/R11 chip select", {24'b0, mem_cs_n},
          {24'b0, (k < t) ? ~(8'h01 << a[27:25]) : 8'hFF});
      if (k < t) chk("R2/R11 address", {7'b0, mem_addr}, {7'b0, a[24:0]});
      chk(wr ? "R6 write enable" : "R3 output enable", {30'b0, mem_oe_n, mem_we_n},
          {30'b0, !oe_exp, !we_exp});
      chk("R9 byte masks", {30'b0, mem_bm_n}, {30'b0, (oe_exp || we_exp) ? ~be : 2'b11});
      chk("R1 ready", {31'b0, req_ready}, {31'b0, k == t});
      chk(wr ? "R8 done" : "R4 done", {31'b0, done}, {31'b0, k == t});
      if (wr && k >= 1 && k < t)
        chk("R7 write data driven", {16'b0, mem_dq}, {16'b0, d});
      else
        chk("R7 bus released", {16'b0, mem_dq}, {16'b0, oe_exp ? 16'(rbase + 16'(k)) : 16'h0});
      if (!wr && k >= m + w)
        chk("R5 read capture", {16'b0, rd_data}, {16'b0, 16'(rbase + 16'(m + w - 1))});
    end
    tb_en = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R2 reset chip selects", {24'b0, mem_cs_n}, 32'hFF);
    chk("R10 reset strobes", {28'b0, mem_oe_n, mem_we_n, mem_bm_n}, 32'hF);
    chk("R1 reset ready", {31'b0, req_ready}, 32'd1);
    chk("R4 reset done", {31'b0, done}, 32'd0);
    chk("R7 reset bus released", {16'b0, mem_dq}, 32'd0);

    access(1'b0, 28'h0123456, 16'h0, 2'b11, 0, 1, 16'h1100);
    access(1'b0, 28'hA5A5A5A, 16'h0, 2'b11, 3, 5, 16'h2200);
    @(negedge clk);
    access(1'b1, 28'h2000001, 16'hBEEF, 2'b11, 0, 1, 16'h0);
    access(1'b1, 28'h6FFFFFF, 16'h5A3C, 2'b01, 2, 4, 16'h0);
    access(1'b1, 28'hE000000, 16'hC381, 2'b10, 1, 3, 16'h0);
    access(1'b0, 28'hFFFFFFF, 16'h0, 2'b11, 15, 16, 16'h7700);
    repeat (2) @(negedge clk);
    access(1'b1, 28'h8765432, 16'hF00F, 2'b11, 15, 16, 16'h0);
    access(1'b0, 28'h4000000, 16'h0, 2'b10, 2, 1, 16'h9900);
    access(1'b0, 28'hC0FFEE0, 16'h0, 2'b01, 0, 7, 16'h3300);

    @(negedge clk);
    #1;
    chk("R10 idle after accesses", {24'b0, mem_cs_n}, 32'hFF);
    chk("R5 read data held", {16'b0, rd_data}, {16'b0, 16'h3300 + 16'd6});
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule